// File: doc/BRIEF.md
# Standby SRAM Bus Access Controller

This block connects a 32-bit internal module bus to a single-port SRAM array that is 16 bits wide. A requester asks for a byte, an aligned 16-bit word or an aligned 32-bit long word, either read or write. The controller runs the request as one or two bus cycles on the array. Each bus cycle lasts two system clocks. A long word is split into two array cycles in big-endian order.

Two conditions limit what the array may do. The first is a synchronous reset request. A write that is already running when reset arrives is allowed to finish. Any write that is requested later, while reset is still asserted, is refused. Reads are still served during reset. The second condition is a flag saying that the array is running from its standby supply. While the flag is set, the array is never selected. Reads finish with their data marked invalid, and writes are refused.

A response is a single-clock done pulse. It carries an error flag, a data-valid flag and the assembled read data. Each bus cycle also produces its own acknowledge, in the second clock of that cycle.

Top module: `sram_bus_ctrl`

## Requirements
- R1: A byte access (size code 2'b00) or an aligned word access (size code 2'b01) runs exactly one bus cycle. It gives one cycle acknowledge, and the done pulse comes two clocks after the request is accepted.
- R2: An aligned long-word access (size code 2'b10) runs two bus cycles. The first cycle carries bits [31:16] at the array word of the address. The second cycle carries bits [15:0] at address+2. The done pulse comes four clocks after acceptance.
- R3: Each bus cycle is two clocks long. The array is selected in the first clock, and `cycAck` is high in the second clock. The done pulse follows the last cycle's acknowledge by one clock.
- R4: A byte write enables only one lane. An even byte address uses the high lane (`arrBe` 2'b10, bits [15:8]). An odd byte address uses the low lane (`arrBe` 2'b01, bits [7:0]). The other byte of the array word is left unchanged.
- R5: A misaligned request is refused. This covers a word at an odd address, a long word whose address bits [1:0] are not 0, and size code 2'b11. The refusal is a done pulse with `rspErr` high, one clock after acceptance. The array is not selected and no cycle acknowledge is given.
- R6: A write that was accepted before `syncReset` rose runs all of its bus cycles and finishes without error.
- R7: A write requested while `syncReset` is high is refused. The done pulse comes one clock later with `rspErr` high, and the array is not changed.
- R8: A read requested while `syncReset` is high and main power is present runs normally and returns valid data.
- R9: While `stbyPower` is high, the array is never selected. A read keeps its normal timing but returns `rspDataValid` low and data 0. A write is refused with an error.
- R10: Read data comes back right-aligned. A byte is zero-extended in [7:0]; an even address returns array bits [15:8] and an odd address returns bits [7:0]. A word is returned in [15:0]. A long word is returned as {first cycle, second cycle}. Writes return `rspDataValid` low.
- R11: Right after reset, `reqReady` is high and `rspDone`, `cycAck` and `arrCs` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset of the controller |
| syncReset | input | 1 | Synchronous reset condition that inhibits new writes |
| stbyPower | input | 1 | Array is running from its standby supply |
| reqValid | input | 1 | Request present; taken when `reqReady` is high |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 2 | 00 byte, 01 word, 10 long word, 11 illegal |
| reqAddr | input | ADDR_W | Byte address |
| reqWData | input | 32 | Write data, right-aligned |
| reqReady | output | 1 | Controller idle, request can be taken |
| cycAck | output | 1 | Second clock of a bus cycle |
| rspDone | output | 1 | One-clock response pulse |
| rspErr | output | 1 | Request refused |
| rspDataValid | output | 1 | Read data is valid |
| rspRData | output | 32 | Read data, right-aligned |
| arrCs | output | 1 | Array select |
| arrWe | output | 1 | Array write enable |
| arrBe | output | 2 | Array lane enables, [1] = bits [15:8] |
| arrAddr | output | ADDR_W-1 | Array word index |
| arrWData | output | 16 | Array write data |
| arrRData | input | 16 | Array read data, valid the clock after select |

## Verification
The assertions check several things on every cycle. Two clocks with array select in a row never happen. Every bus-cycle first clock is followed by its acknowledge clock. A select never occurs under standby power. A write requested during reset never reaches the array. A misaligned request always gets an immediate error with no select. A good response always follows an acknowledge. The bench scenarios are needed for everything that depends on contents: big-endian splitting of a long word, lane merging of byte writes, a write finishing after reset rises in the middle of it, and the exact clock counts measured from acceptance to done.

// File: rtl/sram_bus_pkg.sv
package sram_bus_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSVD = 2'b11
  } accSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;    // latch the accepted request
    logic arrEn;      // select the array this clock
    logic halfSel;    // 0 = first (or only) half, 1 = second half of long
    logic capture;    // array read data is present this clock
    logic blockMark;  // a bus cycle was blocked by standby power
    logic finish;     // last acknowledge of a running access
    logic errFinish;  // refuse request at acceptance
  } ctlStrobe_t;

endpackage

// File: rtl/sram_bus_ctl.sv
module sram_bus_ctl
  import sram_bus_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncReset,
  input  logic       stbyPower,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic [1:0] reqSize,
  input  logic [1:0] reqAddrLow,
  output logic       reqReady,
  output logic       cycAck,
  output ctlStrobe_t ctl
);

  typedef enum logic [1:0] {ST_IDLE, ST_PH0, ST_PH1} ctlState_e;

  ctlState_e stateQ, stateD;
  logic      halfQ, halfD;
  logic      longQ, longD;

  logic      accept;
  logic      illegal;
  logic      writeBlocked;

  assign accept   = (stateQ == ST_IDLE) && reqValid;
  assign reqReady = (stateQ == ST_IDLE);

  always_comb begin
    unique case (accSize_e'(reqSize))
      SZ_BYTE: illegal = 1'b0;
      SZ_WORD: illegal = reqAddrLow[0];
      SZ_LONG: illegal = (reqAddrLow != 2'b00);
      default: illegal = 1'b1;
    endcase
  end

  assign writeBlocked = reqWrite && (syncReset || stbyPower);

  always_comb begin
    stateD = stateQ;
    halfD  = halfQ;
    longD  = longQ;
    ctl    = '0;
    cycAck = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (accept) begin
          if (illegal || writeBlocked) begin
            ctl.errFinish = 1'b1;
          end else begin
            ctl.loadReq = 1'b1;
            halfD       = 1'b0;
            longD       = (accSize_e'(reqSize) == SZ_LONG);
            stateD      = ST_PH0;
          end
        end
      end
      ST_PH0: begin
        ctl.halfSel   = halfQ;
        ctl.arrEn     = !stbyPower;
        ctl.blockMark = stbyPower;
        stateD        = ST_PH1;
      end
      ST_PH1: begin
        ctl.halfSel = halfQ;
        ctl.capture = 1'b1;
        cycAck      = 1'b1;
        if (longQ && !halfQ) begin
          halfD  = 1'b1;
          stateD = ST_PH0;
        end else begin
          ctl.finish = 1'b1;
          stateD     = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      halfQ  <= 1'b0;
      longQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      halfQ  <= halfD;
      longQ  <= longD;
    end
  end

  // R3: the first clock of a bus cycle is always followed by its acknowledge clock
  assert_phase_pair_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_PH0) |=> (stateQ == ST_PH1));

  // R3: an acknowledge is never given in two clocks in a row
  assert_ack_spacing_R3: assert property (@(posedge clk) disable iff (!rstN)
    cycAck |=> !cycAck);

  // R2: the second half of a long word is only reached after a first half
  assert_second_half_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_PH0 && halfQ) |-> $past(stateQ == ST_PH1 && !halfQ));

endmodule

// File: rtl/sram_bus_dp.sv
module sram_bus_dp
  import sram_bus_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BUS_W  = 32,
  parameter int ARR_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BUS_W-1:0]  reqWData,
  output logic              rspDone,
  output logic              rspErr,
  output logic              rspDataValid,
  output logic [BUS_W-1:0]  rspRData,
  output logic              arrCs,
  output logic              arrWe,
  output logic [1:0]        arrBe,
  output logic [ADDR_W-2:0] arrAddr,
  output logic [ARR_W-1:0]  arrWData,
  input  logic [ARR_W-1:0]  arrRData
);

  localparam int LANE_W = ARR_W / 2;
  localparam int IDX_W  = ADDR_W - 1;

  logic [ADDR_W-1:0] addrQ;
  logic [BUS_W-1:0]  wdataQ;
  accSize_e          sizeQ;
  logic              writeQ;
  logic              invalidQ;
  logic [BUS_W-1:0]  rdataQ, rdataD;
  logic [LANE_W-1:0] byteSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      sizeQ  <= SZ_BYTE;
      writeQ <= 1'b0;
    end else if (ctl.loadReq) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWData;
      sizeQ  <= accSize_e'(reqSize);
      writeQ <= reqWrite;
    end
  end

  // array side
  assign arrCs   = ctl.arrEn;
  assign arrWe   = ctl.arrEn && writeQ;
  assign arrAddr = {addrQ[ADDR_W-1:2], addrQ[1] | ctl.halfSel};

  always_comb begin
    unique case (sizeQ)
      SZ_BYTE: begin
        arrWData = {wdataQ[LANE_W-1:0], wdataQ[LANE_W-1:0]};
        arrBe    = addrQ[0] ? 2'b01 : 2'b10;
      end
      SZ_LONG: begin
        arrWData = ctl.halfSel ? wdataQ[ARR_W-1:0] : wdataQ[BUS_W-1:ARR_W];
        arrBe    = 2'b11;
      end
      default: begin
        arrWData = wdataQ[ARR_W-1:0];
        arrBe    = 2'b11;
      end
    endcase
  end

  // read assembly
  assign byteSel = addrQ[0] ? arrRData[LANE_W-1:0] : arrRData[ARR_W-1:LANE_W];

  always_comb begin
    rdataD = rdataQ;
    if (ctl.capture) begin
      unique case (sizeQ)
        SZ_BYTE: rdataD = {{(BUS_W-LANE_W){1'b0}}, byteSel};
        SZ_LONG: begin
          if (ctl.halfSel) rdataD[ARR_W-1:0]     = arrRData;
          else             rdataD[BUS_W-1:ARR_W] = arrRData;
        end
        default: rdataD = {{(BUS_W-ARR_W){1'b0}}, arrRData};
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdataQ   <= '0;
      invalidQ <= 1'b0;
    end else begin
      rdataQ <= rdataD;
      if (ctl.loadReq)        invalidQ <= 1'b0;
      else if (ctl.blockMark) invalidQ <= 1'b1;
    end
  end

  // response registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspDone      <= 1'b0;
      rspErr       <= 1'b0;
      rspDataValid <= 1'b0;
      rspRData     <= '0;
    end else begin
      rspDone      <= ctl.finish || ctl.errFinish;
      rspErr       <= ctl.errFinish || (ctl.finish && writeQ && invalidQ);
      rspDataValid <= ctl.finish && !writeQ && !invalidQ;
      rspRData     <= (ctl.finish && !writeQ && !invalidQ) ? rdataD : '0;
    end
  end

  // R4: a byte write never enables both lanes
  assert_byte_lane_R4: assert property (@(posedge clk) disable iff (!rstN)
    (arrWe && sizeQ == SZ_BYTE) |-> $onehot0(arrBe) && (arrBe != 2'b00));

  // R9: data is never flagged valid after a blocked bus cycle
  assert_blocked_invalid_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.blockMark && !ctl.loadReq) |=> !rspDataValid && !rspDone);

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
  import sram_bus_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BUS_W  = 32,
  parameter int ARR_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncReset,
  input  logic              stbyPower,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BUS_W-1:0]  reqWData,
  output logic              reqReady,
  output logic              cycAck,
  output logic              rspDone,
  output logic              rspErr,
  output logic              rspDataValid,
  output logic [BUS_W-1:0]  rspRData,
  output logic              arrCs,
  output logic              arrWe,
  output logic [1:0]        arrBe,
  output logic [ADDR_W-2:0] arrAddr,
  output logic [ARR_W-1:0]  arrWData,
  input  logic [ARR_W-1:0]  arrRData
);

  ctlStrobe_t ctl;

  sram_bus_ctl ctl_i (
    .clk        (clk),
    .rstN       (rstN),
    .syncReset  (syncReset),
    .stbyPower  (stbyPower),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqSize    (reqSize),
    .reqAddrLow (reqAddr[1:0]),
    .reqReady   (reqReady),
    .cycAck     (cycAck),
    .ctl        (ctl)
  );

  sram_bus_dp #(
    .ADDR_W (ADDR_W),
    .BUS_W  (BUS_W),
    .ARR_W  (ARR_W)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .reqWrite     (reqWrite),
    .reqSize      (reqSize),
    .reqAddr      (reqAddr),
    .reqWData     (reqWData),
    .rspDone      (rspDone),
    .rspErr       (rspErr),
    .rspDataValid (rspDataValid),
    .rspRData     (rspRData),
    .arrCs        (arrCs),
    .arrWe        (arrWe),
    .arrBe        (arrBe),
    .arrAddr      (arrAddr),
    .arrWData     (arrWData),
    .arrRData     (arrRData)
  );

  // R3: array select lasts one clock per bus cycle
  assert_single_select_R3: assert property (@(posedge clk) disable iff (!rstN)
    arrCs |=> !arrCs);

  // R9: no array select while on standby supply
  assert_no_select_standby_R9: assert property (@(posedge clk) disable iff (!rstN)
    stbyPower |-> !arrCs);

  // R7: a write requested during reset never reaches the array
  assert_reset_write_blocked_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid && reqWrite && syncReset) |=> !arrCs && rspDone && rspErr);

  // R5: misaligned or illegal requests are refused at once
  assert_misaligned_err_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid &&
     ((reqSize == 2'b01 && reqAddr[0]) || (reqSize == 2'b10 && reqAddr[1:0] != 2'b00) ||
      reqSize == 2'b11))
    |=> rspDone && rspErr && !arrCs);

  // R1: a successful response always follows a cycle acknowledge
  assert_done_after_ack_R1: assert property (@(posedge clk) disable iff (!rstN)
    (rspDone && !rspErr) |-> $past(cycAck));

endmodule

// File: tb/sram_bus_ctrl_tb.sv
`timescale 1ns/1ps
module sram_bus_ctrl_tb_top;

  localparam int ADDR_W = 12;
  localparam int WORDS  = 2 ** (ADDR_W - 1);
  localparam logic [1:0] SZB = 2'b00, SZW = 2'b01, SZL = 2'b10, SZX = 2'b11;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              syncReset = 1'b0, stbyPower = 1'b0;
  logic              reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0]        reqSize = 2'b00;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [31:0]       reqWData = '0;
  logic              reqReady, cycAck, rspDone, rspErr, rspDataValid;
  logic [31:0]       rspRData;
  logic              arrCs, arrWe;
  logic [1:0]        arrBe;
  logic [ADDR_W-2:0] arrAddr;
  logic [15:0]       arrWData, arrRData;

  int checks = 0, fails = 0, csCount = 0;
  bit testDone = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  sram_bus_ctrl #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .syncReset(syncReset), .stbyPower(stbyPower),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqSize(reqSize), .reqAddr(reqAddr),
    .reqWData(reqWData), .reqReady(reqReady), .cycAck(cycAck), .rspDone(rspDone),
    .rspErr(rspErr), .rspDataValid(rspDataValid), .rspRData(rspRData),
    .arrCs(arrCs), .arrWe(arrWe), .arrBe(arrBe), .arrAddr(arrAddr),
    .arrWData(arrWData), .arrRData(arrRData)
  );

  // behavioural array: registered read, lane-masked write
  logic [15:0] mem [WORDS];
  initial for (int i = 0; i < WORDS; i++) mem[i] = 16'h0000;

  always @(posedge clk) begin
    if (arrCs) begin
      csCount <= csCount + 1;
      if (arrWe) begin
        if (arrBe[1]) mem[arrAddr][15:8] <= arrWData[15:8];
        if (arrBe[0]) mem[arrAddr][7:0]  <= arrWData[7:0];
      end else begin
        arrRData <= mem[arrAddr];
      end
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // runs one request; rstAt >= 0 raises syncReset after that many clocks
  task automatic runAccess(input logic wr, input logic [1:0] sz,
                           input logic [ADDR_W-1:0] ad, input logic [31:0] wd,
                           input int rstAt,
                           output logic err, output logic [31:0] rd,
                           output logic vld, output int acks, output int clks);
    err = 1'bx; rd = 'x; vld = 1'bx; acks = 0; clks = 0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqSize = sz; reqAddr = ad; reqWData = wd;
    @(posedge clk);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      reqValid = 1'b0;
      if (rspDone) begin
        err = rspErr; rd = rspRData; vld = rspDataValid;
        break;
      end
      if (cycAck) acks++;
      clks++;
      if (clks == rstAt) syncReset = 1'b1;
    end
  endtask

  logic e, v; logic [31:0] d; int a, c, csBefore;

  task automatic testReset();
    @(negedge clk);
    check("R11", "reqReady", reqReady, 1);
    check("R11", "rspDone", rspDone, 0);
    check("R11", "cycAck", cycAck, 0);
    check("R11", "arrCs", arrCs, 0);
  endtask

  task automatic testWord();
    runAccess(1, SZW, 12'h100, 32'h0000BEEF, -1, e, d, v, a, c);
    check("R1", "word write clocks", c, 2);
    check("R1", "word write acks", a, 1);
    check("R1", "word write err", e, 0);
    check("R10", "write data valid", v, 0);
    runAccess(0, SZW, 12'h100, 0, -1, e, d, v, a, c);
    check("R10", "word read data", d, 32'h0000BEEF);
    check("R10", "word read valid", v, 1);
    check("R3", "word read clocks", c, 2);
  endtask

  task automatic testByte();
    runAccess(1, SZB, 12'h101, 32'h0000005A, -1, e, d, v, a, c);
    check("R4", "odd byte merge", mem[12'h080], 16'hBE5A);
    runAccess(1, SZB, 12'h100, 32'h00000012, -1, e, d, v, a, c);
    check("R4", "even byte merge", mem[12'h080], 16'h125A);
    check("R1", "byte clocks", c, 2);
    runAccess(0, SZB, 12'h101, 0, -1, e, d, v, a, c);
    check("R10", "odd byte read", d, 32'h0000005A);
    runAccess(0, SZB, 12'h100, 0, -1, e, d, v, a, c);
    check("R10", "even byte read", d, 32'h00000012);
  endtask

  task automatic testLong();
    runAccess(1, SZL, 12'h200, 32'hCAFEF00D, -1, e, d, v, a, c);
    check("R2", "long clocks", c, 4);
    check("R2", "long acks", a, 2);
    check("R2", "high half at addr", mem[12'h100], 16'hCAFE);
    check("R2", "low half at addr+2", mem[12'h101], 16'hF00D);
    runAccess(0, SZL, 12'h200, 0, -1, e, d, v, a, c);
    check("R10", "long read", d, 32'hCAFEF00D);
    check("R10", "long read valid", v, 1);
  endtask

  task automatic testMisaligned();
    csBefore = csCount;
    runAccess(1, SZW, 12'h103, 32'h1111, -1, e, d, v, a, c);
    check("R5", "odd word err", e, 1);
    check("R5", "odd word clocks", c, 0);
    runAccess(1, SZL, 12'h202, 32'h22223333, -1, e, d, v, a, c);
    check("R5", "misaligned long err", e, 1);
    check("R5", "misaligned long acks", a, 0);
    runAccess(0, SZX, 12'h100, 0, -1, e, d, v, a, c);
    check("R5", "size 11 err", e, 1);
    @(negedge clk);
    check("R5", "no array select", csCount, csBefore);
    check("R5", "array untouched", mem[12'h181], 16'h0000);
  endtask

  task automatic testResetInhibit();
    syncReset = 1'b1;
    runAccess(1, SZW, 12'h100, 32'h00007777, -1, e, d, v, a, c);
    check("R7", "reset write err", e, 1);
    check("R7", "array unchanged", mem[12'h080], 16'h125A);
    runAccess(0, SZW, 12'h100, 0, -1, e, d, v, a, c);
    check("R8", "reset read data", d, 32'h0000125A);
    check("R8", "reset read valid", v, 1);
    syncReset = 1'b0;
  endtask

  task automatic testResetMidWrite();
    runAccess(1, SZL, 12'h300, 32'hA1B2C3D4, 1, e, d, v, a, c);
    check("R6", "in-flight err", e, 0);
    check("R6", "in-flight clocks", c, 4);
    check("R6", "in-flight high", mem[12'h180], 16'hA1B2);
    check("R6", "in-flight low", mem[12'h181], 16'hC3D4);
    runAccess(1, SZW, 12'h300, 32'h00009999, -1, e, d, v, a, c);
    check("R7", "later write err", e, 1);
    check("R7", "later write untouched", mem[12'h180], 16'hA1B2);
    syncReset = 1'b0;
  endtask

  task automatic testStandby();
    stbyPower = 1'b1;
    csBefore = csCount;
    runAccess(0, SZW, 12'h100, 0, -1, e, d, v, a, c);
    check("R9", "standby read valid", v, 0);
    check("R9", "standby read data", d, 0);
    check("R9", "standby read clocks", c, 2);
    runAccess(1, SZB, 12'h100, 32'h000000EE, -1, e, d, v, a, c);
    check("R9", "standby write err", e, 1);
    @(negedge clk);
    check("R9", "no select in standby", csCount, csBefore);
    check("R9", "array kept", mem[12'h080], 16'h125A);
    stbyPower = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    testReset();
    testWord();
    testByte();
    testLong();
    testMisaligned();
    testResetInhibit();
    testResetMidWrite();
    testStandby();
    testDone = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!testDone) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule